// File: doc/BRIEF.md
# Iterative Integer Divider with Save/Restore Status

This block is a 32-bit integer divider that sits on a simple register bus with a write strobe, a read strobe, a word address and 32-bit data. Software writes a dividend and a divisor, waits a fixed number of cycles, and then reads a quotient and a remainder. Two address pairs accept the operands: one pair requests unsigned division and the other requests signed division. Both pairs write into the same dividend and divisor storage.

A status word holds a ready flag and a dirty flag. The dirty flag becomes set on any write to an operand or result register. It clears only when the quotient is read. An interrupt handler that finds dirty set must save the operand and result registers before it uses the divider, and it must write them back afterwards. The result registers can be written, and a write to either one cancels any division still running. The restored values therefore survive, and the restore leaves the block ready.

The engine produces four quotient bits per clock, so a 32-bit division takes eight cycles. Sign correction is folded into the last step.

Top module: `divider_regblock`

## Requirements
- R1: Word addresses: 0x18 unsigned dividend, 0x19 unsigned divisor, 0x1A signed dividend, 0x1B signed divisor, 0x1C quotient, 0x1D remainder, 0x1E status. A read of either dividend or divisor address returns the raw stored operand bits, whichever pair wrote them.
- R2: After reset the status word reads 0x1 (bit 0 = ready = 1, bit 1 = dirty = 0, all other bits 0), and quotient and remainder read 0.
- R3: A write to any of the four operand addresses clears ready and sets dirty on the following cycle.
- R4: Ready reads 0 through the seventh clock edge after the last operand write and reads 1 from the eighth. A new operand write restarts the count.
- R5: Unsigned division yields quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R6: Signed division (operands written through 0x1A/0x1B) truncates the quotient toward zero and gives the remainder the sign of the dividend.
- R7: Division by zero completes in the normal latency. For unsigned, the quotient is 0xFFFFFFFF. For signed, the quotient is +1 when the dividend is negative and -1 otherwise. In both cases the remainder equals the dividend.
- R8: Reading the quotient clears dirty. Reading the remainder, an operand register or the status word leaves dirty unchanged.
- R9: Writing the remainder stores the written value, cancels any division in progress so that it cannot overwrite the results, and sets ready and dirty.
- R10: Writing the quotient stores the written value, cancels any division in progress, and sets ready and dirty.
- R11: Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_rd | input | 1 | Read strobe (a quotient read clears dirty) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |

## Verification
The assertions assume that write and read never target the same register in one cycle. They also assume the operand registers are not written while a restore is half done, except in the intended order. The stimulus drives one bus access per cycle, away from the clock edge. The assertions further assume software never reads results before ready. The scoreboard reads results only after ready has been seen. The divide-overflow case (most negative value divided by -1) is not driven, because its expected value is not defined by the requirements.

// File: rtl/divider_pkg.sv
// Package: register addresses and shared sizes for the integer divider.
// Assumes a word-addressed bus; addresses are word indices.
package divider_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_NUM_U = 5'h18;
    localparam logic [ADDR_W-1:0] A_DEN_U = 5'h19;
    localparam logic [ADDR_W-1:0] A_NUM_S = 5'h1A;
    localparam logic [ADDR_W-1:0] A_DEN_S = 5'h1B;
    localparam logic [ADDR_W-1:0] A_QUO   = 5'h1C;
    localparam logic [ADDR_W-1:0] A_REM   = 5'h1D;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h1E;
endpackage

// File: rtl/div_engine.sv
// Module: div_engine
// Restoring divider retiring BPC quotient bits per clock, W/BPC cycles total.
// Assumes num/den stay stable while busy (any operand write restarts it).
// The sign fix-up is applied combinationally to the final step's output.
module div_engine #(
    parameter int W   = 32,
    parameter int BPC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         op_signed,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);
    localparam int STEPS = W / BPC;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

    logic [CW-1:0] cnt;
    logic          sgn;
    logic [W:0]    racc;
    logic [W-1:0]  qsh;
    logic          nneg, dneg, last;
    logic [W-1:0]  absn, absd;
    logic [W:0]    r_v;
    logic [W-1:0]  q_v;

    // operand magnitudes under the latched signedness
    always_comb begin
        nneg = sgn & num[W-1];
        dneg = sgn & den[W-1];
        absn = nneg ? (~num + 1'b1) : num;
        absd = dneg ? (~den + 1'b1) : den;
    end

    // BPC unrolled restoring steps for this cycle
    always_comb begin
        r_v = (cnt == '0) ? '0 : racc;
        q_v = (cnt == '0) ? absn : qsh;
        for (int i = 0; i < BPC; i++) begin
            r_v = {r_v[W-1:0], q_v[W-1]};
            q_v = {q_v[W-2:0], 1'b0};
            if (r_v >= {1'b0, absd}) begin
                r_v     = r_v - {1'b0, absd};
                q_v[0]  = 1'b1;
            end
        end
    end

    // final-step detection and sign correction of the results
    always_comb begin
        last  = busy && (cnt == LAST_CNT);
        done  = last && !start && !abort;
        q_out = (nneg ^ dneg) ? (~q_v + 1'b1) : q_v;
        r_out = nneg ? (~r_v[W-1:0] + 1'b1) : r_v[W-1:0];
    end

    // iteration state: start, abort and per-cycle advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            sgn  <= 1'b0;
            racc <= '0;
            qsh  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            sgn  <= op_signed;
        end else if (busy) begin
            racc <= r_v;
            qsh  <= q_v;
            cnt  <= cnt + 1'b1;
            if (last) busy <= 1'b0;
        end
    end

    // R9
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
    // R3
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy);
    // R4
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/div_flags.sv
// Module: div_flags
// Holds the ready and dirty status bits.
// Assumes op_wr and res_wr are never high together (one write per cycle).
module div_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic op_wr,
    input  logic res_wr,
    input  logic quo_rd,
    input  logic done,
    output logic ready,
    output logic dirty
);
    // ready: cleared by a new operation, set by completion or restore
    always_ff @(posedge clk) begin
        if (!rst_n)                ready <= 1'b1;
        else if (op_wr)            ready <= 1'b0;
        else if (res_wr || done)   ready <= 1'b1;
    end

    // dirty: set by any data write, cleared by a quotient read
    always_ff @(posedge clk) begin
        if (!rst_n)                dirty <= 1'b0;
        else if (op_wr || res_wr)  dirty <= 1'b1;
        else if (quo_rd)           dirty <= 1'b0;
    end

    // R3
    op_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> (dirty && !ready));
    // R8
    quo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quo_rd && !op_wr && !res_wr) |=> !dirty);
    // R10
    restore_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> (dirty && ready));
endmodule

// File: rtl/divider_regblock.sv
// Module: divider_regblock (top)
// Register file for the integer divider: shared operand storage, writable
// results and a status word. Assumes one bus access per cycle; read data
// is combinational from the current address.
module divider_regblock
    import divider_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int BPC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata
);
    logic [WIDTH-1:0] num_r, den_r, quo_r, rem_r;
    logic [WIDTH-1:0] eng_q, eng_r;
    logic wr_num, wr_den, op_wr, op_sgn, wr_quo, wr_rem, res_wr, quo_rd;
    logic busy, done, ready, dirty;

    // address decode of the bus strobes
    always_comb begin
        wr_num = bus_wr && (bus_addr == A_NUM_U || bus_addr == A_NUM_S);
        wr_den = bus_wr && (bus_addr == A_DEN_U || bus_addr == A_DEN_S);
        op_wr  = wr_num || wr_den;
        op_sgn = (bus_addr == A_NUM_S) || (bus_addr == A_DEN_S);
        wr_quo = bus_wr && (bus_addr == A_QUO);
        wr_rem = bus_wr && (bus_addr == A_REM);
        res_wr = wr_quo || wr_rem;
        quo_rd = bus_rd && (bus_addr == A_QUO);
    end

    // shared operand storage for both signedness windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_r <= '0;
            den_r <= '0;
        end else begin
            if (wr_num) num_r <= bus_wdata;
            if (wr_den) den_r <= bus_wdata;
        end
    end

    // result registers: restored by writes, loaded on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
        end else begin
            if (wr_quo)    quo_r <= bus_wdata;
            else if (done) quo_r <= eng_q;
            if (wr_rem)    rem_r <= bus_wdata;
            else if (done) rem_r <= eng_r;
        end
    end

    div_engine #(.W(WIDTH), .BPC(BPC)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(op_wr), .abort(res_wr),
        .op_signed(op_sgn), .num(num_r), .den(den_r),
        .busy(busy), .done(done), .q_out(eng_q), .r_out(eng_r)
    );

    div_flags u_flags (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .res_wr(res_wr),
        .quo_rd(quo_rd), .done(done), .ready(ready), .dirty(dirty)
    );

    // read data multiplexer
    always_comb begin
        case (bus_addr)
            A_NUM_U, A_NUM_S: bus_rdata = num_r;
            A_DEN_U, A_DEN_S: bus_rdata = den_r;
            A_QUO:            bus_rdata = quo_r;
            A_REM:            bus_rdata = rem_r;
            A_STAT:           bus_rdata = {{(WIDTH-2){1'b0}}, dirty, ready};
            default:          bus_rdata = '0;
        endcase
    end

    // R4
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);
    // R9
    rem_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rem |=> (rem_r == $past(bus_wdata)));
    // R10
    quo_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_quo |=> (quo_r == $past(bus_wdata)));
endmodule

// File: tb/divider_regblock_tb.sv
module divider_regblock_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit driver_done = 1'b0;
    bit reported = 1'b0;

    logic [63:0] exp_q[$];
    logic [63:0] obs_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    divider_regblock u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one write, effective at the next rising edge; returns at the next falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // one read: data sampled now, side effect at the next rising edge
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit sgn);
        logic [31:0] q, r;
        int sa, sb;
        if (!sgn) begin
            if (b == 0) begin q = 32'hFFFF_FFFF; r = a; end
            else begin q = a / b; r = a % b; end
        end else begin
            sa = $signed(a); sb = $signed(b);
            if (sb == 0) begin q = (sa < 0) ? 32'd1 : 32'hFFFF_FFFF; r = a; end
            else begin q = 32'(sa / sb); r = 32'(sa % sb); end
        end
        return {q, r};
    endfunction

    // driver: issue a division, push expected, read back and push observed
    task automatic do_div(input logic [31:0] a, input logic [31:0] b, input bit sgn, input string req);
        logic [31:0] st, q, r;
        exp_q.push_back(model(a, b, sgn));
        tag_q.push_back(req);
        wr(sgn ? 5'h1A : 5'h18, a);
        wr(sgn ? 5'h1B : 5'h19, b);
        repeat (8) @(negedge clk);
        rd(5'h1E, st);
        check("R4 ready after latency", st, 32'h3);
        rd(5'h1D, r);
        rd(5'h1C, q);
        obs_q.push_back({q, r});
    endtask

    // monitor: compare observed results against the expected queue
    initial begin
        forever begin
            logic [63:0] e, o;
            string t;
            wait (obs_q.size() > 0);
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            t = tag_q.pop_front();
            check({t, " quotient"}, o[63:32], e[63:32]);
            check({t, " remainder"}, o[31:0], e[31:0]);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(5'h1E, v); check("R2 status", v, 32'h1);
        rd(5'h1C, v); check("R2 quotient", v, 32'h0);
        rd(5'h1D, v); check("R2 remainder", v, 32'h0);

        // R5 unsigned patterns
        do_div(32'd100, 32'd7, 1'b0, "R5");
        do_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R5");
        do_div(32'd5, 32'd10, 1'b0, "R5");
        do_div(32'h8000_0000, 32'd3, 1'b0, "R5");
        do_div(32'hDEAD_BEEF, 32'h0001_2345, 1'b0, "R5");
        // R6 signed patterns
        do_div(-32'sd7, 32'sd2, 1'b1, "R6");
        do_div(32'sd7, -32'sd2, 1'b1, "R6");
        do_div(-32'sd7, -32'sd2, 1'b1, "R6");
        do_div(32'h8000_0000, 32'sd7, 1'b1, "R6");
        // R7 division by zero
        do_div(32'd1234, 32'd0, 1'b0, "R7");
        do_div(-32'sd9, 32'd0, 1'b1, "R7");
        do_div(32'sd9, 32'd0, 1'b1, "R7");

        // R1 shared storage, raw readback through both windows
        wr(5'h1A, -32'sd5);
        rd(5'h18, v); check("R1 dividend raw via unsigned", v, 32'hFFFF_FFFB);
        rd(5'h1A, v); check("R1 dividend raw via signed", v, 32'hFFFF_FFFB);
        // R3 flags right after an operand write
        wr(5'h1B, 32'd3);
        rd(5'h1E, v); check("R3 status after operand write", v, 32'h2);
        rd(5'h19, v); check("R1 divisor raw", v, 32'd3);

        // R4 exact latency and restart on a second write
        repeat (8) @(negedge clk);
        wr(5'h18, 32'd50);
        repeat (5) @(negedge clk);
        wr(5'h19, 32'd6);
        repeat (7) @(negedge clk);
        rd(5'h1E, v); check("R4 not ready at edge 7", v, 32'h2);
        rd(5'h1E, v); check("R4 ready at edge 8", v, 32'h3);

        // R8 only a quotient read clears dirty
        rd(5'h1D, v); check("R5 remainder 50/6", v, 32'd2);
        rd(5'h18, v);
        rd(5'h1E, v); check("R8 dirty kept after other reads", v, 32'h3);
        rd(5'h1C, v); check("R5 quotient 50/6", v, 32'd8);
        rd(5'h1E, v); check("R8 dirty cleared by quotient read", v, 32'h1);

        // R11 status writes ignored
        wr(5'h1E, 32'h2);
        rd(5'h1E, v); check("R11 status unchanged", v, 32'h1);

        // R9/R10 restore cancels an in-flight division
        wr(5'h18, 32'd100);
        wr(5'h19, 32'd7);
        wr(5'h1D, 32'h55);
        rd(5'h1E, v); check("R9 ready and dirty after remainder write", v, 32'h3);
        wr(5'h1C, 32'h66);
        rd(5'h1E, v); check("R10 ready and dirty after quotient write", v, 32'h3);
        repeat (10) @(negedge clk);
        rd(5'h1D, v); check("R9 remainder kept", v, 32'h55);
        rd(5'h1C, v); check("R10 quotient kept", v, 32'h66);
        rd(5'h1E, v); check("R8 dirty cleared after restore", v, 32'h1);

        driver_done = 1'b1;
        wait (obs_q.size() == 0);
        repeat (2) @(negedge clk);
        report();
    end
endmodule